// File: doc/BRIEF.md
# Bank Coordinate Translator

This block sits in the memory-side network interface of a tiled chip. For each outgoing cache request it takes the physical address and the ID of the requesting processor. It returns the X/Y mesh coordinate of the cache bank tile that owns that line. The mapping comes from a small table of sixteen programmable entries. The table is indexed by four bits taken from the physical address.

Two interleave modes exist. In shared mode, consecutive 64-byte lines are spread across all sixteen entries. In split mode, the top bit of the index comes from the processor ID, so each processor interleaves its lines across its own eight entries. Software can rewrite any entry while the block runs. This moves an address range from one bank tile to another, for example when a bank is taken out of cache service and used as scratchpad.

The result is registered. It appears one cycle after the request together with a response valid flag, and it holds between requests.

Top module: `bank_xlate`

## Requirements
- R1: While `rst_n` is low at a clock edge, `rsp_valid`, `rsp_x` and `rsp_y` clear to 0. Every table entry i returns to the identity coordinate x = i mod 4, y = i div 4.
- R2: In shared mode (`split_mode` = 0), the table index is address bits [9:6], with bit 9 as the most significant index bit.
- R3: In split mode (`split_mode` = 1), the index is {`req_proc`, address bits [8:6]}. Address bit 9 has no effect on the result.
- R4: `rsp_valid` is high in exactly the cycles that follow a cycle with `req_valid` high. In those cycles `rsp_x`/`rsp_y` carry the entry selected by that request.
- R5: A write (`wr_en` = 1) stores {`wr_x`, `wr_y`} into entry `wr_idx`. A lookup of the same entry in the same cycle returns the old value. Lookups in later cycles return the new value.
- R6: A write changes only entry `wr_idx`. Without `wr_en`, no entry changes.
- R7: When `req_valid` is low, `rsp_x`/`rsp_y` keep their previous value.
- R8: Address bits [5:0] and bits above bit 9 have no effect on the result.
- R9: In shared mode, `req_proc` has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | 40 | Physical address of the request |
| req_proc | input | 1 | ID of the requesting processor |
| split_mode | input | 1 | 0 = interleave over 16 entries, 1 = 8 entries per processor |
| wr_en | input | 1 | Table write strobe |
| wr_idx | input | 4 | Entry to rewrite |
| wr_x | input | 2 | New X coordinate |
| wr_y | input | 3 | New Y coordinate |
| rsp_valid | output | 1 | Coordinate valid, one cycle after a request |
| rsp_x | output | 2 | X coordinate of the target bank tile |
| rsp_y | output | 3 | Y coordinate of the target bank tile |

## Verification
The bench probes a write and a lookup of the same entry in the same cycle. A design that forwarded the new value would return the remapped coordinate one cycle early and misroute a request in flight. In split mode it sets address bit 9 against the processor ID. A design that kept bit 9 in the index would send one processor's lines into the other's half. It also checks that address bits outside [9:6] and the processor ID in shared mode leave the result alone. It checks that a single write leaves neighbouring entries intact and that a reset restores the identity map after a remap. A design that failed these would scatter lines to wrong banks or lose the remap state.

// File: rtl/bank_xlate_pkg.sv
// Package: shared widths and the coordinate type for the bank translator.
// Assumes a 4-column by up-to-8-row mesh of bank tiles.
package bank_xlate_pkg;
    parameter int X_W      = 2;
    parameter int Y_W      = 3;
    parameter int IDX_W    = 4;
    parameter int ENTRIES  = 1 << IDX_W;
    parameter int LINE_OFS = 6;
    parameter int ADDR_W   = 40;

    typedef struct packed {
        logic [X_W-1:0] x;
        logic [Y_W-1:0] y;
    } coord_t;
endpackage

// File: rtl/bxl_index_sel.sv
// Module: forms the table index from the line-address bits.
// In shared mode the index is the IDX_W bits above the line offset. In split
// mode the processor ID replaces the top bit. Assumes one processor ID bit.
module bxl_index_sel #(
    parameter int IDX_W = 4
) (
    input  logic [IDX_W-1:0] line_bits,
    input  logic             proc_id,
    input  logic             split,
    output logic [IDX_W-1:0] idx
);
    // Pick the index source according to the interleave mode.
    always_comb begin
        if (split) idx = {proc_id, line_bits[IDX_W-2:0]};
        else       idx = line_bits;
    end
endmodule

// File: rtl/bxl_table.sv
// Module: the programmable coordinate table.
// One register per entry, reset to the identity map. A single write port
// updates one entry per cycle. All entries are exported so the caller can mux.
module bxl_table
    import bank_xlate_pkg::*;
#(
    parameter int N     = ENTRIES,
    parameter int IW    = IDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  coord_t        wr_data,
    output coord_t [N-1:0] ent
);
    localparam int COLS = 1 << X_W;

    for (genvar i = 0; i < N; i++) begin : g_ent
        localparam logic [X_W-1:0] RST_X = X_W'(i % COLS);
        localparam logic [Y_W-1:0] RST_Y = Y_W'(i / COLS);
        // Hold entry i, reload identity on reset, take a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                ent[i] <= '{x: RST_X, y: RST_Y};
            else if (wr_en && (wr_idx == IW'(i)))
                ent[i] <= wr_data;
        end
    end
endmodule

// File: rtl/bxl_resp_reg.sv
// Module: registers the looked-up coordinate and its valid flag.
// The coordinate only loads on a request and holds otherwise.
module bxl_resp_reg
    import bank_xlate_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   load,
    input  coord_t d,
    output logic   valid,
    output coord_t q
);
    // Valid follows the request one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) valid <= 1'b0;
        else        valid <= load;
    end

    // Capture the coordinate on a request, hold it between requests.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= d;
    end
endmodule

// File: rtl/bank_xlate.sv
// Module: top of the bank coordinate translator.
// Selects a table index from the address, the processor ID and the mode.
// Reads the table and registers the coordinate. A write in the same cycle
// as a lookup of that entry is seen only from the next cycle.
module bank_xlate
    import bank_xlate_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_proc,
    input  logic              split_mode,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [X_W-1:0]    wr_x,
    input  logic [Y_W-1:0]    wr_y,
    output logic              rsp_valid,
    output logic [X_W-1:0]    rsp_x,
    output logic [Y_W-1:0]    rsp_y
);
    localparam int FIELD_HI = LINE_OFS + IDX_W;

    logic [IDX_W-1:0]     idx;
    coord_t [ENTRIES-1:0] ent_all;
    coord_t               rd_coord;
    coord_t               rsp_q;
    logic                 unused_addr;

    // Fold the address bits that never steer the lookup.
    assign unused_addr = ^{req_addr[ADDR_W-1:FIELD_HI], req_addr[LINE_OFS-1:0]};

    bxl_index_sel #(.IDX_W(IDX_W)) u_idx (
        .line_bits (req_addr[FIELD_HI-1:LINE_OFS]),
        .proc_id   (req_proc),
        .split     (split_mode),
        .idx       (idx)
    );

    bxl_table u_tbl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data ('{x: wr_x, y: wr_y}),
        .ent     (ent_all)
    );

    // Read the selected entry from the current (pre-write) table state.
    always_comb rd_coord = ent_all[idx];

    bxl_resp_reg u_rsp (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (req_valid),
        .d     (rd_coord),
        .valid (rsp_valid),
        .q     (rsp_q)
    );

    assign rsp_x = rsp_q.x;
    assign rsp_y = rsp_q.y;
endmodule

// File: rtl/bank_xlate_chk.sv
// Checker: temporal properties of the translator, bound to the top.
module bank_xlate_chk
    import bank_xlate_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 wr_en,
    input logic [IDX_W-1:0]     wr_idx,
    input logic [X_W-1:0]       wr_x,
    input logic [Y_W-1:0]       wr_y,
    input logic                 rsp_valid,
    input logic [X_W-1:0]       rsp_x,
    input logic [Y_W-1:0]       rsp_y,
    input coord_t [ENTRIES-1:0] ent_all
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (!rsp_valid && rsp_x == '0 && rsp_y == '0));

    // R4
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R4
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R7
    coord_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable({rsp_x, rsp_y}));

    // R5
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ent_all[$past(wr_idx)] == $past({wr_x, wr_y})));

    // R6
    table_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ent_all));
endmodule

bind bank_xlate bank_xlate_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_x      (wr_x),
    .wr_y      (wr_y),
    .rsp_valid (rsp_valid),
    .rsp_x     (rsp_x),
    .rsp_y     (rsp_y),
    .ent_all   (ent_all)
);

// File: tb/bank_xlate_tb.sv
`timescale 1ns/1ps
module bank_xlate_tb;
    localparam int VW = 1 + 1 + 40 + 2 + 3;
    localparam int NV = 9;
    // {split, proc, addr, exp_x, exp_y} with the identity table
    localparam logic [VW-1:0] VEC [NV] = '{
        {1'b0, 1'b0, 40'h00_0000_0040, 2'd1, 3'd0},   // R2 index 1
        {1'b0, 1'b0, 40'h00_0000_03C0, 2'd3, 3'd3},   // R2 index 15
        {1'b0, 1'b0, 40'h00_0000_02BF, 2'd2, 3'd2},   // R8 low bits set, index 10
        {1'b0, 1'b0, 40'hFF_FFFF_FD80, 2'd2, 3'd1},   // R8 high bits set, index 6
        {1'b0, 1'b1, 40'h00_0000_0140, 2'd1, 3'd1},   // R9 proc ignored, index 5
        {1'b1, 1'b0, 40'h00_0000_03C0, 2'd3, 3'd1},   // R3 proc0, index 7
        {1'b1, 1'b1, 40'h00_0000_01C0, 2'd3, 3'd3},   // R3 proc1, index 15
        {1'b1, 1'b1, 40'h00_0000_0200, 2'd0, 3'd2},   // R3 bit 9 ignored, index 8
        {1'b1, 1'b0, 40'h00_0000_0280, 2'd2, 3'd0}    // R3 proc0, index 2
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [39:0] req_addr = '0;
    logic        req_proc = 1'b0;
    logic        split_mode = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [1:0]  wr_x = '0;
    logic [2:0]  wr_y = '0;
    logic        rsp_valid;
    logic [1:0]  rsp_x;
    logic [2:0]  rsp_y;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    bank_xlate u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_proc(req_proc), .split_mode(split_mode), .wr_en(wr_en),
        .wr_idx(wr_idx), .wr_x(wr_x), .wr_y(wr_y),
        .rsp_valid(rsp_valid), .rsp_x(rsp_x), .rsp_y(rsp_y)
    );

    task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // One lookup; result sampled at the falling edge after the capture edge.
    task automatic lookup(input logic sp, input logic pr, input logic [39:0] a,
                          input logic [1:0] ex, input logic [2:0] ey, input string req);
        @(negedge clk);
        split_mode = sp; req_proc = pr; req_addr = a; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; wr_en = 1'b0;
        check(req, {rsp_valid, rsp_x, rsp_y}, {1'b1, ex, ey});
    endtask

    initial begin
        #1_000_000;
        n_bad++; n_chk++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset outputs", {rsp_valid, rsp_x, rsp_y}, 6'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R4 idle no valid", {rsp_valid, rsp_x, rsp_y}, 6'd0);

        for (int i = 0; i < NV; i++) begin
            lookup(VEC[i][46], VEC[i][45], VEC[i][44:5], VEC[i][4:3], VEC[i][2:0],
                   "R2/R3/R8/R9 vector");
        end

        // R7: idle cycles keep the last coordinate (index 2 -> x2 y0)
        repeat (2) @(negedge clk);
        check("R7 hold", {rsp_valid, rsp_x, rsp_y}, {1'b0, 2'd2, 3'd0});

        // R5: write entry 5 while looking it up; old value comes back
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 4'd5; wr_x = 2'd0; wr_y = 3'd6;
        split_mode = 1'b0; req_proc = 1'b0; req_addr = 40'h140; req_valid = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; req_valid = 1'b0;
        check("R5 same-cycle old value", {rsp_valid, rsp_x, rsp_y}, {1'b1, 2'd1, 3'd1});
        lookup(1'b0, 1'b0, 40'h140, 2'd0, 3'd6, "R5 new value");
        // R6: neighbours untouched
        lookup(1'b0, 1'b0, 40'h100, 2'd0, 3'd1, "R6 entry 4 kept");
        lookup(1'b0, 1'b0, 40'h180, 2'd2, 3'd1, "R6 entry 6 kept");

        // R5/R3: remap entry 9, reach it through split mode proc1
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 4'd9; wr_x = 2'd3; wr_y = 3'd7;
        @(negedge clk);
        wr_en = 1'b0;
        lookup(1'b1, 1'b1, 40'h040, 2'd3, 3'd7, "R5 split remap");
        lookup(1'b1, 1'b0, 40'h040, 2'd1, 3'd0, "R6 entry 1 kept");

        // R1: reset restores identity map
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset clears", {rsp_valid, rsp_x, rsp_y}, 6'd0);
        rst_n = 1'b1;
        lookup(1'b0, 1'b0, 40'h140, 2'd1, 3'd1, "R1 identity restored 5");
        lookup(1'b0, 1'b0, 40'h240, 2'd1, 3'd2, "R1 identity restored 9");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule